// File: doc/BRIEF.md
# Dual-Mode 64-Bit Lane Scrambler and Descrambler

This block scrambles one 64-bit lane word per clock on transmit and descrambles one 64-bit word per clock on receive. Both directions use the generator polynomial x^58 + x^39 + 1, each with its own 58-bit shift register. A static mode input picks one of two modes for both directions.

In synchronous (additive) mode, a free-running LFSR produces a keystream that is XORed onto the data. The LFSR starts from a per-lane 15-bit seed. Each lane instance needs a different seed, and the transmitter and receiver of one link must share the same seed. In this mode, a check word carries the transmitter's raw LFSR state, so the receiver can confirm that its own LFSR is aligned.

In self-synchronizing (multiplicative) mode, the scrambled bits themselves feed the shift register. The receiver therefore locks after 58 received bits without any seed. This is the mode a 10GBASE-R style lane uses; the synchronous mode suits an Interlaken style lane.

Parameters choose whether the scrambling stage is present, whether the descrambling stage is present, and whether the error flag is present.

Top module: `lane_scrambler58`

## Requirements
- R1: In self-synchronizing mode (`mode_selfsync`=1), words are processed LSB first. Transmit output bit i equals data bit i XOR the output bit sent 39 bits earlier XOR the output bit sent 58 bits earlier. Bits earlier in the same word count toward this history.
- R2: In self-synchronizing mode, once one full valid word has been received, the descrambler's output equals the original data, whatever state the receiver held before.
- R3: In synchronous mode (`mode_selfsync`=0), reset or `seed_load` puts the 15-bit seed into state bits [14:0] and clears all other state bits. For each bit, the keystream bit is state[38] XOR state[57]. That keystream bit is shifted into state[0] and XORed onto the data. As a result, a zero first word scrambles to zero in bits [23:0], and bit i for i = 24..38 equals seed bit 38-i.
- R4: In synchronous mode, a receiver that uses the same seed and sees the same sequence of valid words recovers the original data.
- R5: In synchronous mode, a transmit word flagged by `tx_check` is sent as the raw 58-bit state in bits [57:0] with zeros in bits [63:58]. The state still advances 64 steps. In self-synchronizing mode, `tx_check` and `rx_check` are ignored.
- R6: In synchronous mode, a receive word flagged by `rx_check` is passed through unchanged. `rx_err` is 1 exactly when bits [57:0] of that word differ from the local receive state. `rx_err` is 0 on every other output word, and always 0 in self-synchronizing mode.
- R7: Each output word appears one clock after its input, with `tx_out_valid`/`rx_out_valid` equal to the input valid one clock earlier.
- R8: A direction's state changes only on a valid word or on `seed_load`. Idle cycles do not disturb the stream that follows.
- R9: With scrambling disabled by parameter, the transmit output equals the input data. With descrambling disabled, the receive output equals the input data.
- R10: With the error flag disabled by parameter, `rx_err` stays 0, even for a mismatching check word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the seed |
| mode_selfsync | input | 1 | Static mode: 1 self-synchronizing, 0 synchronous |
| seed_load | input | 1 | Reloads both states from the seed |
| tx_valid | input | 1 | Transmit input word valid |
| tx_check | input | 1 | Send the state check word instead of data (synchronous mode) |
| tx_data | input | 64 | Transmit data word, bit 0 first |
| tx_out_valid | output | 1 | Transmit output valid |
| tx_out_data | output | 64 | Scrambled transmit word |
| rx_valid | input | 1 | Receive input word valid |
| rx_check | input | 1 | Received word is a state check word (synchronous mode) |
| rx_data | input | 64 | Scrambled receive word, bit 0 first |
| rx_out_valid | output | 1 | Receive output valid |
| rx_out_data | output | 64 | Descrambled receive word |
| rx_err | output | 1 | Check word disagreed with the local state |

## Verification
The hardest condition to reach from the ports is a receiver whose state is unknown and must recover from it. In self-synchronizing mode, the bench first feeds the receiver unrelated junk words. It then checks that every descrambled word after the first word of the real stream is exact. In synchronous mode, the error flag is forced by corrupting one bit of a check word in flight while the transmitter stays aligned. Idle gaps are placed mid-stream to show that the state holds across them.

// File: rtl/lane_scrambler58.sv
module lane_scrambler58 #(
  parameter int W      = 64,
  parameter int SL     = 58,
  parameter int TAP    = 39,
  parameter int SEED_W = 15,
  parameter logic [SEED_W-1:0] SEED = 15'h5A3C,
  parameter bit TX_EN  = 1'b1,
  parameter bit RX_EN  = 1'b1,
  parameter bit ERR_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_selfsync,
  input  logic         seed_load,
  input  logic         tx_valid,
  input  logic         tx_check,
  input  logic [W-1:0] tx_data,
  output logic         tx_out_valid,
  output logic [W-1:0] tx_out_data,
  input  logic         rx_valid,
  input  logic         rx_check,
  input  logic [W-1:0] rx_data,
  output logic         rx_out_valid,
  output logic [W-1:0] rx_out_data,
  output logic         rx_err
);

  localparam logic [SL-1:0] SEED_EXT = {{(SL-SEED_W){1'b0}}, SEED};

  logic [SL-1:0] tx_st, rx_st, tx_nxt, rx_nxt;
  logic [W-1:0]  tx_scr, rx_dsc, tx_word, rx_word, tx_chk;
  logic          rx_mis;

  always_comb begin
    logic [SL-1:0] t;
    logic fb;
    t = tx_st;
    tx_scr = '0;
    for (int i = 0; i < W; i++) begin
      fb = t[TAP-1] ^ t[SL-1];
      tx_scr[i] = tx_data[i] ^ fb;
      t = {t[SL-2:0], mode_selfsync ? tx_scr[i] : fb};
    end
    tx_nxt = t;
  end

  always_comb begin
    logic [SL-1:0] r;
    logic fb;
    r = rx_st;
    rx_dsc = '0;
    for (int i = 0; i < W; i++) begin
      fb = r[TAP-1] ^ r[SL-1];
      rx_dsc[i] = rx_data[i] ^ fb;
      r = {r[SL-2:0], mode_selfsync ? rx_data[i] : fb};
    end
    rx_nxt = r;
  end

  always_comb begin
    tx_chk = '0;
    tx_chk[SL-1:0] = tx_st;
  end

  assign tx_word = !TX_EN ? tx_data : (!mode_selfsync && tx_check) ? tx_chk : tx_scr;
  assign rx_word = (!RX_EN || (!mode_selfsync && rx_check)) ? rx_data : rx_dsc;
  assign rx_mis  = ERR_EN && !mode_selfsync && rx_check && (rx_data[SL-1:0] != rx_st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_st        <= SEED_EXT;
      rx_st        <= SEED_EXT;
      tx_out_valid <= 1'b0;
      rx_out_valid <= 1'b0;
      tx_out_data  <= '0;
      rx_out_data  <= '0;
      rx_err       <= 1'b0;
    end else begin
      if (seed_load) begin
        tx_st <= SEED_EXT;
        rx_st <= SEED_EXT;
      end else begin
        if (tx_valid) tx_st <= tx_nxt;
        if (rx_valid) rx_st <= rx_nxt;
      end
      tx_out_valid <= tx_valid;
      rx_out_valid <= rx_valid;
      if (tx_valid) tx_out_data <= tx_word;
      if (rx_valid) rx_out_data <= rx_word;
      rx_err <= rx_valid && rx_mis;
    end
  end

  a_r7_tx_latency: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid == $past(tx_valid));
  a_r7_rx_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid == $past(rx_valid));
  a_r6_err_with_word: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> rx_out_valid);
  a_r6_no_err_selfsync: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_selfsync && $past(mode_selfsync)) |-> !rx_err);
  a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && !seed_load) |=> $stable(tx_st));
  a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !seed_load) |=> $stable(rx_st));
  a_r3_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (tx_st == SEED_EXT && rx_st == SEED_EXT));

  generate
    if (!TX_EN) begin : g_txbyp
      a_r9_tx_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_valid |-> tx_out_data == $past(tx_data));
    end
    if (!RX_EN) begin : g_rxbyp
      a_r9_rx_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        rx_out_valid |-> rx_out_data == $past(rx_data));
    end
  endgenerate

endmodule

// File: tb/test_lane_scrambler58.sv
module test_lane_scrambler58;
  localparam int CLK = 10;
  localparam logic [14:0] SEED = 15'h5A3C;

  logic clk = 0, rst_n = 0, mode_selfsync = 0, seed_load = 0;
  logic tx_valid = 0, tx_check = 0, rx_valid = 0, rx_check = 0;
  logic [63:0] tx_data = '0, rx_data = '0;
  logic tx_out_valid, rx_out_valid, rx_err, b_txv, b_rxv, b_err;
  logic [63:0] tx_out_data, rx_out_data, b_txd, b_rxd;
  int checks = 0, fails = 0;

  always #(CLK/2) clk = ~clk;

  lane_scrambler58 #(.SEED(SEED)) i_lane_scrambler58 (
    .clk, .rst_n, .mode_selfsync, .seed_load, .tx_valid, .tx_check, .tx_data,
    .tx_out_valid, .tx_out_data, .rx_valid, .rx_check, .rx_data,
    .rx_out_valid, .rx_out_data, .rx_err);

  lane_scrambler58 #(.SEED(SEED), .TX_EN(1'b0), .RX_EN(1'b0), .ERR_EN(1'b0)) i_lane_scrambler58_byp (
    .clk, .rst_n, .mode_selfsync, .seed_load, .tx_valid, .tx_check, .tx_data,
    .tx_out_valid(b_txv), .tx_out_data(b_txd), .rx_valid, .rx_check, .rx_data,
    .rx_out_valid(b_rxv), .rx_out_data(b_rxd), .rx_err(b_err));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // kind 0: additive keystream, 1: self-sync transmit, 2: self-sync receive
  function automatic logic [121:0] mstep(input logic [57:0] s, input logic [63:0] d, input int kind);
    logic [63:0] o;
    logic k;
    o = '0;
    for (int i = 0; i < 64; i++) begin
      k = s[38] ^ s[57];
      o[i] = d[i] ^ k;
      s = {s[56:0], (kind == 0) ? k : (kind == 1) ? o[i] : d[i]};
    end
    return {s, o};
  endfunction

  function automatic logic [63:0] pat(input int p, input int k);
    case (p)
      0: return '0;
      1: return '1;
      2: return 64'h1 << (k % 64);
      3: return {k[31:0], ~k[31:0]};
      default: return 64'h9E3779B97F4A7C15 * 64'(k + 7 * p + 1);
    endcase
  endfunction

  task automatic cyc(input logic tv, input logic tc, input logic [63:0] td,
                     input logic rv, input logic rc, input logic [63:0] rd);
    @(negedge clk);
    seed_load = 0;
    tx_valid = tv; tx_check = tc; tx_data = td;
    rx_valid = rv; rx_check = rc; rx_data = rd;
    @(posedge clk); #1;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [57:0] mt;
    logic [63:0] exp_tx, d, rd, sexp;
    logic [121:0] r;
    logic tc, first;
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset tx valid", {63'b0, tx_out_valid}, 64'd0);
    check("R7 reset rx valid", {63'b0, rx_out_valid}, 64'd0);
    check("R6 reset err", {63'b0, rx_err}, 64'd0);
    @(negedge clk); rst_n = 1;

    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      mode_selfsync = m[0]; seed_load = 1;
      @(posedge clk); #1;
      check("R7 idle after load", {63'b0, tx_out_valid}, 64'd0);
      mt = {43'b0, SEED};
      if (m == 1) begin
        cyc(0, 0, '0, 1, 0, 64'hDEAD_BEEF_0BAD_F00D);
        cyc(0, 0, '0, 1, 0, 64'h1234_5678_9ABC_DEF0);
      end
      first = 1;
      for (int p = 0; p < 5; p++) begin
        for (int k = 0; k < 12; k++) begin
          d = pat(p, k);
          tc = (k == 5 || k == 8);
          if (m == 0 && tc) begin
            exp_tx = {6'b0, mt};
            r = mstep(mt, d, 0);
            mt = r[121:64];
          end else begin
            r = mstep(mt, d, m);
            mt = r[121:64];
            exp_tx = r[63:0];
          end
          rd = exp_tx;
          if (m == 0 && k == 8) rd[3] = ~rd[3];
          cyc(1, tc, d, 1, tc, rd);
          check(m ? "R1 selfsync tx word" : "R3 sync tx word", tx_out_data, exp_tx);
          if (m == 0 && p == 0 && k == 0) begin
            sexp = '0;
            for (int i = 24; i <= 38; i++) sexp[i] = SEED[38 - i];
            check("R3 seed keystream", tx_out_data & 64'h0000_007F_FFFF_FFFF, sexp);
          end
          check("R7 tx valid", {63'b0, tx_out_valid}, 64'd1);
          check("R7 rx valid", {63'b0, rx_out_valid}, 64'd1);
          if (m == 0 && tc) begin
            check("R5 check word passes raw", rx_out_data, rd);
            check("R6 check word err", {63'b0, rx_err}, {63'b0, k == 8});
          end else begin
            if (!(m == 1 && first))
              check(m ? "R2 selfsync recover" : "R4 sync recover", rx_out_data, d);
            check(m ? "R5 selfsync check ignored err" : "R6 no err on data", {63'b0, rx_err}, 64'd0);
          end
          check("R9 tx bypass", b_txd, d);
          check("R9 rx bypass", b_rxd, rd);
          check("R10 err disabled", {63'b0, b_err}, 64'd0);
          first = 0;
          if (k == 9) begin
            for (int j = 0; j < 3; j++) begin
              cyc(0, 0, 64'hFFFF_0000_FFFF_0000, 0, 0, 64'h0F0F_0F0F_0F0F_0F0F);
              check("R8 idle tx valid low", {63'b0, tx_out_valid}, 64'd0);
              check("R8 idle rx valid low", {63'b0, rx_out_valid}, 64'd0);
            end
          end
        end
      end
      cyc(0, 0, '0, 0, 0, '0);
    end
    finish_run();
  end
endmodule